// File: doc/BRIEF.md
# Slot Lifecycle Order Monitor

This block watches one resource slot through three single-cycle event strobes: a claim (allocate), a fill (set) and a release (deallocate). It keeps its own copy of the slot's occupancy and contents-valid bits. It also tracks which event it must see next, and raises a sticky error when the strobes break the claim, fill, release order or when more than one of them fires in the same cycle. Every state element updates on the falling clock edge.

An active-high initialization input is high during the first cycle only. In that cycle it blocks all strobes and clears the model. If it rises again later, the block re-initializes and records that as an error. The model's occupancy and valid bits, the error flag and code, and an indication that the block is waiting for a claim are all visible at the ports. A surrounding checker or testbench can compare them against the slot it is monitoring.

Top module: `slot_order_monitor`

## Requirements
- R1: Outputs change only at the falling clock edge. After an input change, they hold their value until that edge.
- R2: The next occupancy bit equals (allocate OR occupancy) AND NOT deallocate, using the qualified strobes.
- R3: The next valid bit equals occupancy AND (set OR valid). Valid therefore cannot rise in the cycle after a set that came while the slot was free.
- R4: In a cycle with initialization high, all strobes are ignored. At the edge, occupancy and valid clear, the order state becomes waiting-for-allocate (idle output 1), and the error flag and code (0) clear. The exception is R9.
- R5: The accepted order is allocate, then set, then deallocate, then allocate again, with any number of quiet cycles between strobes. A legal strobe advances the order state and raises no error. The idle output is 1 only while an allocate is expected.
- R6: Two or more strobes in one cycle set the error flag with code 1. The order state does not move.
- R7: A single strobe other than the expected one sets the error flag with code 2. The order state does not move.
- R8: The first error's code is held, and later errors do not change it. The flag stays at 1 until an initialization cycle.
- R9: Initialization high in a cycle that follows a non-initialization cycle re-initializes the model as in R4, but sets the error flag with code 3. A second consecutive initialization cycle clears it.
- R10: After initialization, a set or deallocate that comes before any allocate is an order error (code 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on its falling edge |
| init_i | input | 1 | Active-high initialization, high during the first cycle |
| alloc_i | input | 1 | Allocate strobe |
| set_i | input | 1 | Set strobe |
| dealloc_i | input | 1 | Deallocate strobe |
| active_o | output | 1 | Model occupancy bit |
| valid_o | output | 1 | Model contents-valid bit |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 2 | First error code: 0 none, 1 simultaneous, 2 out of order, 3 re-initialization |
| idle_o | output | 1 | High while an allocate is the expected next strobe |

## Verification
Suppose the order state is wrong, for example it advances on an illegal strobe or misses a legal one. The idle output is then wrong after the next falling edge, and the next legal strobe produces a spurious code 2 one edge after it arrives. A wrong occupancy or valid bit appears on the ports at the same edge as the strobe that caused it. A bad valid bit then propagates, because it feeds its own next value. An error-capture fault shows as a code that changes under a later error, or as a flag that falls without an initialization cycle. Both are visible at the edge that follows the second error.

// File: rtl/slot_mon_pkg.sv
package slot_mon_pkg;

    localparam int NUM_STROBES = 3;
    localparam int CODE_W      = 2;

    typedef enum logic [1:0] {
        ORD_IDLE  = 2'd0,
        ORD_ALLOC = 2'd1,
        ORD_SET   = 2'd2
    } ord_e;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE   = 2'd0,
        ERR_MULTI  = 2'd1,
        ERR_ORDER  = 2'd2,
        ERR_REINIT = 2'd3
    } err_e;

    typedef struct packed {
        logic alloc;
        logic set;
        logic dealloc;
    } strobe_t;

    typedef struct packed {
        ord_e ord;
        logic active;
        logic valid;
        logic err;
        err_e code;
        logic run;
    } mon_state_t;

endpackage

// File: rtl/slot_mon_gate.sv
module slot_mon_gate
    import slot_mon_pkg::*;
(
    input  logic    init_i,
    input  strobe_t raw_i,
    output strobe_t gated_o,
    output logic    any_o,
    output logic    multi_o
);
    localparam int CNT_W = $clog2(NUM_STROBES + 1);

    logic [CNT_W-1:0] hot_cnt;

    always_comb begin
        gated_o = init_i ? '0 : raw_i;
        hot_cnt = CNT_W'(gated_o.alloc) + CNT_W'(gated_o.set) + CNT_W'(gated_o.dealloc);
        any_o   = (hot_cnt != '0);
        multi_o = (hot_cnt > CNT_W'(1));
    end
endmodule

// File: rtl/slot_mon_order.sv
module slot_mon_order
    import slot_mon_pkg::*;
(
    input  ord_e    cur_i,
    input  strobe_t stb_i,
    input  logic    any_i,
    input  logic    multi_i,
    output ord_e    nxt_o,
    output logic    viol_o
);
    logic expected;
    ord_e after;

    always_comb begin
        unique case (cur_i)
            ORD_IDLE:  begin expected = stb_i.alloc;   after = ORD_ALLOC; end
            ORD_ALLOC: begin expected = stb_i.set;     after = ORD_SET;   end
            ORD_SET:   begin expected = stb_i.dealloc; after = ORD_IDLE;  end
            default:   begin expected = 1'b0;          after = ORD_IDLE;  end
        endcase
        viol_o = any_i && !multi_i && !expected;
        nxt_o  = (any_i && !multi_i && expected) ? after : cur_i;
    end
endmodule

// File: rtl/slot_mon_model.sv
module slot_mon_model
    import slot_mon_pkg::*;
(
    input  logic    active_i,
    input  logic    valid_i,
    input  strobe_t stb_i,
    output logic    active_nxt_o,
    output logic    valid_nxt_o
);
    always_comb begin
        active_nxt_o = (stb_i.alloc | active_i) & ~stb_i.dealloc;
        valid_nxt_o  = active_i & (stb_i.set | valid_i);
    end
endmodule

// File: rtl/slot_order_monitor.sv
module slot_order_monitor
    import slot_mon_pkg::*;
(
    input  logic              clk,
    input  logic              init_i,
    input  logic              alloc_i,
    input  logic              set_i,
    input  logic              dealloc_i,
    output logic              active_o,
    output logic              valid_o,
    output logic              err_o,
    output logic [CODE_W-1:0] err_code_o,
    output logic              idle_o
);
    mon_state_t st_d, st_q;
    strobe_t    raw, gated;
    logic       any_hot, multi_hot, order_viol;
    logic       act_nxt, val_nxt;
    ord_e       ord_nxt;

    assign raw = '{alloc: alloc_i, set: set_i, dealloc: dealloc_i};

    slot_mon_gate u_gate (
        .init_i  (init_i),
        .raw_i   (raw),
        .gated_o (gated),
        .any_o   (any_hot),
        .multi_o (multi_hot)
    );

    slot_mon_order u_order (
        .cur_i   (st_q.ord),
        .stb_i   (gated),
        .any_i   (any_hot),
        .multi_i (multi_hot),
        .nxt_o   (ord_nxt),
        .viol_o  (order_viol)
    );

    slot_mon_model u_model (
        .active_i     (st_q.active),
        .valid_i      (st_q.valid),
        .stb_i        (gated),
        .active_nxt_o (act_nxt),
        .valid_nxt_o  (val_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d.ord    = ORD_IDLE;
            st_d.active = 1'b0;
            st_d.valid  = 1'b0;
            st_d.run    = 1'b0;
            if (st_q.run) begin
                st_d.err  = 1'b1;
                st_d.code = ERR_REINIT;
            end else begin
                st_d.err  = 1'b0;
                st_d.code = ERR_NONE;
            end
        end else begin
            st_d.run    = 1'b1;
            st_d.active = act_nxt;
            st_d.valid  = val_nxt;
            st_d.ord    = ord_nxt;
            if (!st_q.err && (multi_hot || order_viol)) begin
                st_d.err  = 1'b1;
                st_d.code = multi_hot ? ERR_MULTI : ERR_ORDER;
            end
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign active_o   = st_q.active;
    assign valid_o    = st_q.valid;
    assign err_o      = st_q.err;
    assign err_code_o = st_q.code;
    assign idle_o     = (st_q.ord == ORD_IDLE);
endmodule

// File: rtl/slot_mon_checker.sv
module slot_mon_checker
    import slot_mon_pkg::*;
(
    input logic              clk,
    input logic              init_i,
    input logic              alloc_i,
    input logic              set_i,
    input logic              dealloc_i,
    input logic              active_o,
    input logic              valid_o,
    input logic              err_o,
    input logic [CODE_W-1:0] err_code_o,
    input logic              idle_o
);
    a_r2_active_eq: assert property (@(negedge clk) disable iff (init_i)
        !init_i |=> (active_o == (($past(alloc_i) | $past(active_o)) & ~$past(dealloc_i))));

    a_r3_valid_eq: assert property (@(negedge clk) disable iff (init_i)
        !init_i |=> (valid_o == ($past(active_o) & ($past(set_i) | $past(valid_o)))));

    a_r4_init_clears: assert property (@(negedge clk) disable iff (init_i)
        $fell(init_i) |-> (!active_o && !valid_o && idle_o));

    a_r6_multi_code: assert property (@(negedge clk) disable iff (init_i)
        (!err_o && ($countones({alloc_i, set_i, dealloc_i}) > 1)) |=>
            (err_o && err_code_o == ERR_MULTI));

    a_r8_sticky: assert property (@(negedge clk) disable iff (init_i)
        err_o |=> (err_o && $stable(err_code_o)));
endmodule

bind slot_order_monitor slot_mon_checker u_chk (
    .clk        (clk),
    .init_i     (init_i),
    .alloc_i    (alloc_i),
    .set_i      (set_i),
    .dealloc_i  (dealloc_i),
    .active_o   (active_o),
    .valid_o    (valid_o),
    .err_o      (err_o),
    .err_code_o (err_code_o),
    .idle_o     (idle_o)
);

// File: tb/sim_slot_order_monitor.sv
module sim_slot_order_monitor;
    localparam time PERIOD = 10;

    typedef struct {
        logic       act;
        logic       val;
        logic       err;
        logic [1:0] code;
        logic       idle;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       init_i = 1'b1, alloc_i = 1'b0, set_i = 1'b0, dealloc_i = 1'b0;
    logic       active_o, valid_o, err_o, idle_o;
    logic [1:0] err_code_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    exp_t q[$];

    // bench model of the requirements
    int         m_ord = 0;
    logic       m_act = 0, m_val = 0, m_err = 0, m_run = 0;
    logic [1:0] m_code = 0;
    bit         have_prev = 0;

    always #(PERIOD/2) clk = ~clk;

    slot_order_monitor u0 (
        .clk(clk), .init_i(init_i), .alloc_i(alloc_i), .set_i(set_i),
        .dealloc_i(dealloc_i), .active_o(active_o), .valid_o(valid_o),
        .err_o(err_o), .err_code_o(err_code_o), .idle_o(idle_o)
    );

    function automatic void compare(input exp_t e);
        n_cmp++;
        if (active_o !== e.act || valid_o !== e.val || err_o !== e.err ||
            err_code_o !== e.code || idle_o !== e.idle) begin
            n_bad++;
            $display("FAIL %s: act/val/err/code/idle actual %b%b%b %0d %b expected %b%b%b %0d %b",
                     e.tag, active_o, valid_o, err_o, err_code_o, idle_o,
                     e.act, e.val, e.err, e.code, e.idle);
        end
    endfunction

    task automatic step(input logic i, input logic a, input logic s, input logic d,
                        input string tag);
        exp_t prev, e;
        logic ga, gs, gd, nact, nval, exp_hit;
        int hot;
        @(posedge clk);
        #1;
        prev = '{m_act, m_val, m_err, m_code, (m_ord == 0), "R1"};
        init_i = i; alloc_i = a; set_i = s; dealloc_i = d;
        ga = i ? 1'b0 : a; gs = i ? 1'b0 : s; gd = i ? 1'b0 : d;
        if (i) begin
            m_act = 0; m_val = 0; m_ord = 0;
            if (m_run) begin m_err = 1; m_code = 3; end
            else begin m_err = 0; m_code = 0; end
            m_run = 0;
        end else begin
            nact = (ga | m_act) & ~gd;
            nval = m_act & (gs | m_val);
            hot = int'(ga) + int'(gs) + int'(gd);
            exp_hit = (m_ord == 0) ? ga : (m_ord == 1) ? gs : gd;
            if (hot > 1) begin
                if (!m_err) begin m_err = 1; m_code = 1; end
            end else if (hot == 1) begin
                if (exp_hit) m_ord = (m_ord + 1) % 3;
                else if (!m_err) begin m_err = 1; m_code = 2; end
            end
            m_act = nact; m_val = nval; m_run = 1;
        end
        e = '{m_act, m_val, m_err, m_code, (m_ord == 0), tag};
        q.push_back(e);
        #2;
        if (have_prev) compare(prev); // R1: no change before the falling edge
        have_prev = 1;
    endtask

    always @(posedge clk) begin
        if (q.size() > 0) compare(q.pop_front());
    end

    initial begin
        #(PERIOD * 2000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(1, 1, 0, 0, "R4 init ignores strobe");
        step(0, 0, 0, 0, "R5 quiet");
        step(0, 1, 0, 0, "R2 allocate");
        step(0, 0, 0, 0, "R5 quiet after allocate");
        step(0, 0, 0, 0, "R5 quiet after allocate 2");
        step(0, 0, 1, 0, "R3 set while active");
        step(0, 0, 0, 0, "R3 valid holds");
        step(0, 0, 0, 1, "R2 deallocate");
        step(0, 1, 0, 0, "R5 reallocate");
        step(0, 0, 1, 0, "R5 set");
        step(0, 0, 0, 1, "R5 deallocate");
        step(1, 0, 0, 0, "R9 reinit code 3");
        step(1, 0, 0, 0, "R4 second init clears");
        step(0, 0, 1, 0, "R10 set before allocate");
        step(0, 1, 0, 0, "R8 code held after legal allocate");
        step(0, 1, 0, 0, "R7 R8 repeated allocate");
        step(1, 0, 0, 0, "R9 reinit");
        step(1, 0, 0, 0, "R4 clear");
        step(0, 1, 1, 0, "R6 simultaneous");
        step(0, 0, 1, 0, "R3 R8 set while idle order");
        step(0, 0, 0, 1, "R2 deallocate out of order");
        step(0, 0, 0, 0, "R3 valid falls");
        step(1, 0, 0, 0, "R9 reinit");
        step(1, 0, 0, 0, "R4 clear");
        step(0, 1, 0, 0, "R5 allocate");
        step(0, 0, 0, 1, "R7 deallocate before set");
        step(0, 0, 1, 0, "R7 order state kept");
        step(0, 0, 0, 1, "R5 deallocate to idle");
        step(0, 0, 0, 0, "R5 quiet");
        @(posedge clk);
        #1;
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule